// File: doc/BRIEF.md
# Per-Pin Multi-Mode GPIO Interrupt Detector

This block watches a bank of general-purpose pins and records, per pin, a sticky interrupt flag whenever that pin shows the kind of activity its trigger setting asks for. Every pin has its own trigger setting: a falling edge, a rising edge, a move to a low level, a move to a high level, or any edge. The setting comes from three sensitivity vectors. Pins that are outputs, pins whose interrupt is disabled, and input pins that are frozen never raise a flag. A single combined interrupt line is high whenever any flag is set. Software clears flags by writing ones through a write-one-to-clear strobe.

Each pin passes through a synchroniser before anything else sees it. The synchronised value then feeds a sample register. The sample register is held while the pin is a frozen input. Detection compares the next sample with the current one, so a level trigger fires only on entry into its active level. A level that simply persists never sets a flag. The register storage, the bus decode and any debounce timing sit outside the block. They present their vectors to this block as plain inputs.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin's trigger code is {sens2_i[n], sens1_i[n], sens0_i[n]}. Code 000 selects falling edge: the flag sets when the sample moves from 1 to 0, and never when it moves from 0 to 1.
- R2: Code 001 selects rising edge: the flag sets when the sample moves from 0 to 1, and never when it moves from 1 to 0.
- R3: Code 010 selects low level: the flag sets when the sample changes to 0. Once cleared, it is not set again while the pin stays low.
- R4: Code 011 selects high level: the flag sets when the sample changes to 1. Once cleared, it is not set again while the pin stays high.
- R5: Any code with bit 2 set (1xx) selects both edges: the flag sets on every change of the sample in either direction.
- R6: A pin with en_i[n]=0 never sets its flag.
- R7: A pin with dir_i[n]=1 (output) never sets its flag.
- R8: For an input pin with freeze_i[n]=1, the sample holds its last value and the pin sets no flag. After the freeze is released, a difference between the held sample and the pin is detected as a change.
- R9: Flags are sticky. While clr_en_i=1, each 1 in clr_data_i clears the matching flag at the next clock edge. A 0 in clr_data_i leaves its flag unchanged.
- R10: If a clear and a new trigger hit the same flag at the same edge, the flag ends up set.
- R11: irq_o is high exactly when status_o is non-zero, and both change on the same edge.
- R12: Synchronous reset clears the flags, irq_o, the synchroniser and the sample register. A pin change driven before a clock edge first appears in status_o on the third rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| dir_i | input | NUM_PINS | 1 = output pin, 0 = input pin |
| freeze_i | input | NUM_PINS | 1 = hold the sample of an input pin |
| en_i | input | NUM_PINS | Per-pin interrupt enable |
| sens0_i | input | NUM_PINS | Trigger code bit 0 |
| sens1_i | input | NUM_PINS | Trigger code bit 1 |
| sens2_i | input | NUM_PINS | Trigger code bit 2 |
| clr_en_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | NUM_PINS | Flags to clear while the strobe is high |
| status_o | output | NUM_PINS | Sticky interrupt flags |
| irq_o | output | 1 | High while any flag is set |

## Verification
A clear write and a fresh trigger can land on the same flag at the same clock edge. The bench provokes this by raising a rising-edge pin exactly two negative edges before a full clear strobe. That timing places the detection edge on the clear edge. The bench then expects that flag alone to remain set, with every other flag cleared. The random phase mixes clears, freezes and direction changes with pin toggles, and a behavioural model judges each cycle, so further collisions of clear, freeze release and edges are compared there as well.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TRIG_FALL = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_LOW  = 3'b010,
    TRIG_HIGH = 3'b011,
    TRIG_BOTH = 3'b100
  } trig_code_e;

  // True when a sample step from 'was' to 'now' satisfies the trigger code.
  function automatic logic trig_match(input logic [CODE_W-1:0] code,
                                      input logic was,
                                      input logic now);
    logic moved;
    logic r;
    moved = was ^ now;
    if (code[CODE_W-1]) begin
      r = moved;
    end else begin
      case (trig_code_e'(code))
        TRIG_FALL: r = moved & ~now;
        TRIG_RISE: r = moved &  now;
        TRIG_LOW:  r = moved & ~now;
        TRIG_HIGH: r = moved &  now;
        default:   r = moved;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/gpio_irq_sample.sv
module gpio_irq_sample #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] freeze_i,
  output logic [WIDTH-1:0] smp_q_o,
  output logic [WIDTH-1:0] smp_next_o
);

  logic [WIDTH-1:0] hold;
  logic [WIDTH-1:0] smp_q;

  // Only input pins honour the freeze mask.
  assign hold       = freeze_i & ~dir_i;
  assign smp_next_o = (hold & smp_q) | (~hold & sync_i);

  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else     smp_q <= smp_next_o;
  end

  assign smp_q_o = smp_q;

endmodule

// File: rtl/gpio_irq_eval.sv
module gpio_irq_eval
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] smp_q_i,
  input  logic [WIDTH-1:0] smp_next_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] sens0_i,
  input  logic [WIDTH-1:0] sens1_i,
  input  logic [WIDTH-1:0] sens2_i,
  output logic [WIDTH-1:0] hit_o
);

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              armed;
    assign code     = {sens2_i[n], sens1_i[n], sens0_i[n]};
    assign armed    = en_i[n] & ~dir_i[n];
    assign hit_o[n] = armed & trig_match(code, smp_q_i[n], smp_next_i[n]);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic             irq_q;

  assign clr_mask = clr_en_i ? clr_data_i : '0;
  // A new hit is merged after the clear, so it survives a collision.
  assign status_d = (status_q & ~clr_mask) | hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] freeze_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] sens0_i,
  input  logic [NUM_PINS-1:0] sens1_i,
  input  logic [NUM_PINS-1:0] sens2_i,
  input  logic                clr_en_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] smp_q;
  logic [NUM_PINS-1:0] smp_next;
  logic [NUM_PINS-1:0] hit;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  gpio_irq_sample #(.WIDTH(NUM_PINS)) u_sample (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (pin_sync),
    .dir_i      (dir_i),
    .freeze_i   (freeze_i),
    .smp_q_o    (smp_q),
    .smp_next_o (smp_next)
  );

  gpio_irq_eval #(.WIDTH(NUM_PINS)) u_eval (
    .smp_q_i    (smp_q),
    .smp_next_i (smp_next),
    .dir_i      (dir_i),
    .en_i       (en_i),
    .sens0_i    (sens0_i),
    .sens1_i    (sens1_i),
    .sens2_i    (sens2_i),
    .hit_o      (hit)
  );

  gpio_irq_status #(.WIDTH(NUM_PINS)) u_status (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .clr_en_i   (clr_en_i),
    .clr_data_i (clr_data_i),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] dir_i,
  input logic [NUM_PINS-1:0] freeze_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic                clr_en_i,
  input logic [NUM_PINS-1:0] clr_data_i,
  input logic [NUM_PINS-1:0] status_o,
  input logic                irq_o
);

  logic [NUM_PINS-1:0] clr_mask;
  assign clr_mask = clr_en_i ? clr_data_i : '0;

  assert_irq_tracks_status_R11: assert property (@(posedge clk)
    disable iff (rst) irq_o == (status_o != '0));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status_o) & ~$past(clr_mask)) & ~status_o) == '0));

  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(en_i)) == '0));

  assert_output_silent_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & ~$past(status_o) & $past(dir_i)) == '0));

  assert_frozen_silent_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & ~$past(status_o) & $past(freeze_i & ~dir_i)) == '0));

  assert_reset_clears_R12: assert property (@(posedge clk)
    $past(rst) |-> (status_o == '0 && !irq_o));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_i      (dir_i),
  .freeze_i   (freeze_i),
  .en_i       (en_i),
  .clr_en_i   (clr_en_i),
  .clr_data_i (clr_data_i),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins = '0, dir = '0, frz = '0, en = '0;
  logic [N-1:0] s0 = '0, s1 = '0, s2 = '0, clr_data = '0;
  logic         clr_en = 1'b0;
  logic [N-1:0] status;
  logic         irq;

  int    n_checks = 0;
  int    n_err = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string cur_req = "R12";

  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_smp = '0, m_st = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N), .SYNC_STAGES(2)) i_gpio_irq_detect (
    .clk(clk), .rst(rst), .pin_i(pins), .dir_i(dir), .freeze_i(frz),
    .en_i(en), .sens0_i(s0), .sens1_i(s1), .sens2_i(s2),
    .clr_en_i(clr_en), .clr_data_i(clr_data),
    .status_o(status), .irq_o(irq)
  );

  // Behavioural reference, stepped on each rising edge.
  always @(posedge clk) begin : model
    logic [N-1:0] nx;
    logic [N-1:0] fire;
    int code;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_smp = '0; m_st = '0;
    end else begin
      fire = '0;
      for (int i = 0; i < N; i++) begin
        nx[i] = (frz[i] && !dir[i]) ? m_smp[i] : m_s2[i];
        code = {29'd0, s2[i], s1[i], s0[i]};
        if (en[i] && !dir[i] && nx[i] != m_smp[i]) begin
          if (code >= 4)       fire[i] = 1'b1;
          else if (code == 0)  fire[i] = !nx[i];
          else if (code == 1)  fire[i] = nx[i];
          else if (code == 2)  fire[i] = !nx[i];
          else                 fire[i] = nx[i];
        end
      end
      if (clr_en) m_st = m_st & ~clr_data;
      m_st  = m_st | fire;
      m_smp = nx;
      m_s2  = m_s1;
      m_s1  = pins;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk({cur_req, " model status"}, status, m_st);
      chk("R11 irq vs model", {31'd0, irq}, {31'd0, m_st != '0});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_en = 1'b1; clr_data = '1;
    cyc(1);
    clr_en = 1'b0; clr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Pins 0-3 fall, 4-7 rise, 8-11 low, 12-15 high, 16-19 code 100,
    // 20-23 code 111, 24-31 rise; 24-27 disabled, 28-29 outputs, 30-31 frozen.
    s0  = 32'hFFF0_F0F0 | 32'h00F0_0000;
    s1  = 32'h00F0_FF00;
    s2  = 32'h00FF_0000;
    en  = 32'hF0FF_FFFF;
    dir = 32'h3000_0000;
    frz = 32'hC000_0000;
    cyc(3);
    rst = 1'b0;
    cmp_on = 1;
    cyc(4);
    chk("R12 reset status", status, '0);
    chk("R12 reset irq", {31'd0, irq}, '0);

    cur_req = "R12";
    pins = 32'h0000_0010;
    cyc(2);
    chk("R12 latency two edges", status, '0);
    cyc(1);
    chk("R12 latency third edge", status, 32'h0000_0010);
    chk("R11 irq with flag", {31'd0, irq}, 32'd1);
    pins = '0;
    cyc(4);
    clear_all();
    chk("R9 clear all", status, '0);
    chk("R11 irq after clear", {31'd0, irq}, '0);

    cur_req = "R2";
    pins = '1;
    cyc(5);
    chk("R2 rising pins", status & 32'h0000_00F0, 32'h0000_00F0);
    chk("R1 falling quiet on rise", status & 32'h0000_000F, '0);
    chk("R4 high entry", status & 32'h0000_F000, 32'h0000_F000);
    chk("R5 both edges on rise", status & 32'h00FF_0000, 32'h00FF_0000);
    chk("R6 disabled pins", status & 32'h0F00_0000, '0);
    chk("R7 output pins", status & 32'h3000_0000, '0);
    chk("R8 frozen pins", status & 32'hC000_0000, '0);
    chk("R2 full vector", status, 32'h00FF_F0F0);

    cur_req = "R4";
    clear_all();
    cyc(10);
    chk("R4 persisting high no relatch", status, '0);

    cur_req = "R1";
    pins = '0;
    cyc(5);
    chk("R1 falling pins", status & 32'h0000_000F, 32'h0000_000F);
    chk("R3 low entry", status & 32'h0000_0F00, 32'h0000_0F00);
    chk("R5 both edges on fall", status & 32'h00FF_0000, 32'h00FF_0000);
    chk("R1 full vector", status, 32'h00FF_0F0F);

    cur_req = "R9";
    clr_en = 1'b1; clr_data = '0;
    cyc(1);
    clr_en = 1'b0;
    chk("R9 zero write keeps flags", status, 32'h00FF_0F0F);
    clr_en = 1'b1; clr_data = 32'h0000_000F;
    cyc(1);
    clr_en = 1'b0; clr_data = '0;
    chk("R9 partial clear", status, 32'h00FF_0F00);
    clear_all();
    cur_req = "R3";
    cyc(10);
    chk("R3 persisting low no relatch", status, '0);

    cur_req = "R8";
    pins = 32'hC000_0000;
    cyc(5);
    chk("R8 frozen pin held", status, '0);
    frz = '0;
    cyc(2);
    chk("R8 release detects change", status, 32'hC000_0000);
    clear_all();

    cur_req = "R10";
    pins = 32'hC000_0010;
    cyc(2);
    clr_en = 1'b1; clr_data = '1;
    cyc(1);
    clr_en = 1'b0; clr_data = '0;
    chk("R10 trigger beats clear", status, 32'h0000_0010);
    chk("R11 irq on collision", {31'd0, irq}, 32'd1);

    cur_req = "R5";
    for (int k = 0; k < 600; k++) begin
      pins = $urandom;
      if ((k % 7) == 0) begin
        clr_en = 1'b1; clr_data = $urandom;
      end else begin
        clr_en = 1'b0; clr_data = '0;
      end
      if ((k % 50) == 0) frz = $urandom;
      if ((k % 80) == 0) dir = $urandom;
      cyc(1);
    end
    clr_en = 1'b0;
    cyc(3);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk("R12 reset mid-run", status, '0);
    cyc(2);
    finish_run();
  end

endmodule